// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the two modem registers of a byte-wide serial port. The status register samples four incoming handshake lines: carrier detect, ring, data-set-ready and clear-to-send. Each line passes through a multi-flop synchronizer. The register keeps the current level of each line and latches a sticky change flag for it. The control register drives four outgoing lines: terminal-ready, request-to-send and two general-purpose outputs. It also holds a loop-test bit.

When loop-test is set, the outgoing lines are forced inactive. A status read then reports the control bits on crossed status positions, and the external lines are kept from raising change flags. A registered summary output, `delta_any`, tells the interrupt logic that at least one change flag is pending.

Software reaches both registers through one read strobe, one write strobe and a one-bit register select. Select 0 picks the control register and select 1 picks the status register. Read data is registered.

Top module: `mdm_ctrl_stat`

## Requirements
- R1: Status bits 7:4 show carrier detect (bit 7), ring (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). Each bit follows its input line. A line change is visible on the third rising edge after it is applied (two synchronizer flops, then the status register).
- R2: Status bit 3 latches a change of carrier detect, bit 1 a change of data-set-ready and bit 0 a change of clear-to-send. The change can be in either direction, and each flag stays set until it is cleared.
- R3: Status bit 2 latches only a falling ring line (1 to 0). A rising ring line leaves it unchanged.
- R4: A status read outside loop-test returns the value held before the read edge and clears bits 3:0. Bits 7:4 are left unchanged. A change that lands on the read edge is kept for the next read.
- R5: A control write stores bits 4:0 of the write data. A control read returns them with bits 7:5 as zero. Outside loop-test, the pins follow the stored bits: `out_dtr` bit 0, `out_rts` bit 1, `out_aux1` bit 2 and `out_aux2` bit 3. The pins update on the write edge.
- R6: While control bit 4 (loop-test) is set, all four output pins are low.
- R7: In loop-test, a status read returns control bit 3 as bit 7, bit 2 as bit 6, bit 0 as bit 5 and bit 1 as bit 4, with bits 3:0 read as zero. In this mode a read clears no flag, and the external lines set no flag.
- R8: After reset, the status register reads 0xB0, the control register reads 0x08, only `out_aux2` is high and `delta_any` is low.
- R9: `delta_any` is high exactly when any of status bits 3:0 is set in the stored flags. It updates on the same edge as the flags.
- R10: Line changes made during loop-test raise no flag after loop-test ends.
- R11: `rd_data` changes only on an edge where `reg_rd_en` is high. It is loaded from the register picked by `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe (control register only) |
| reg_rd_en | input | 1 | Read strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| line_cts | input | 1 | Clear-to-send line, asynchronous |
| line_dsr | input | 1 | Data-set-ready line, asynchronous |
| line_dcd | input | 1 | Carrier-detect line, asynchronous |
| line_ri | input | 1 | Ring line, asynchronous |
| out_dtr | output | 1 | Terminal-ready output |
| out_rts | output | 1 | Request-to-send output |
| out_aux1 | output | 1 | General-purpose output 1 |
| out_aux2 | output | 1 | General-purpose output 2 |
| delta_any | output | 1 | At least one change flag is pending |

## Verification
The assertions take for granted that the four lines stay stable long enough to be sampled. A level held for less than one clock period could pass the synchronizer unseen. The assertions also expect reset to be held for several clocks, so that every past value they use comes from a reset register.

The stimulus changes each line at a falling clock edge and holds it for at least four cycles before sampling. The one deliberate exception is a line change placed so that its flag lands on the same edge as a status read, which checks that the flag is not lost.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NIB_W = 4;
  localparam int CTL_W = 5;
  typedef logic [NIB_W-1:0] nib_t;

  // status nibble positions (order is architectural)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // control register positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_AUX1 = 2;
  localparam int C_AUX2 = 3;
  localparam int C_LOOP = 4;

  localparam nib_t             STAT_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST  = 5'b01000;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTL_W-1:0]  ctl_o,
  output nib_t              pins_o
);
  localparam nib_t PINS_RST = CTL_RST[NIB_W-1:0] & ~{NIB_W{CTL_RST[C_LOOP]}};

  logic [CTL_W-1:0] ctl_q;
  nib_t             pins_q;
  logic             ctl_unused;

  assign ctl_unused = ^wdata_i[DATA_W-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= CTL_RST;
      pins_q <= PINS_RST;
    end else if (wr_en_i) begin
      ctl_q  <= wdata_i[CTL_W-1:0];
      pins_q <= wdata_i[NIB_W-1:0] & ~{NIB_W{wdata_i[C_LOOP]}};
    end
  end

  assign ctl_o  = ctl_q;
  assign pins_o = pins_q;

  AST_LOOP_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
    ctl_q[C_LOOP] |-> (pins_q == '0)); // R6
  AST_PINS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[C_LOOP] |-> (pins_q == ctl_q[NIB_W-1:0])); // R5
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(ctl_q)); // R5
endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  nib_t               ext_i,
  input  logic               loop_i,
  input  nib_t               loop_lines_i,
  input  logic               rd_clr_i,
  output logic [2*NIB_W-1:0] word_o,
  output logic               delta_any_o
);
  nib_t stat_q, delta_q, delta_n, hit;
  logic clr;
  logic any_q;

  generate
    for (genvar g = 0; g < NIB_W; g++) begin : g_delta
      if (g == L_RI) begin : g_fall
        assign hit[g] = stat_q[g] & ~ext_i[g] & ~loop_i;
      end else begin : g_any
        assign hit[g] = (stat_q[g] ^ ext_i[g]) & ~loop_i;
      end
    end
  endgenerate

  assign clr = rd_clr_i & ~loop_i;

  always_comb begin
    delta_n = (delta_q & ~{NIB_W{clr}}) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= STAT_RST;
      delta_q <= '0;
      any_q   <= 1'b0;
    end else begin
      stat_q  <= ext_i;
      delta_q <= delta_n;
      any_q   <= |delta_n;
    end
  end

  assign word_o      = loop_i ? {loop_lines_i, {NIB_W{1'b0}}} : {stat_q, delta_q};
  assign delta_any_o = any_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_q == $past(ext_i))); // R1
  AST_RING_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!loop_i && !stat_q[L_RI] && ext_i[L_RI]) |=>
      (delta_q[L_RI] == $past(delta_q[L_RI] & ~rd_clr_i))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !loop_i && (stat_q == ext_i)) |=> (delta_q == '0)); // R4
  AST_LOOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    loop_i |=> $stable(delta_q)); // R7
endmodule

// File: rtl/mdm_ctrl_stat.sv
module mdm_ctrl_stat
  import mdm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              line_cts,
  input  logic              line_dsr,
  input  logic              line_dcd,
  input  logic              line_ri,
  output logic              out_dtr,
  output logic              out_rts,
  output logic              out_aux1,
  output logic              out_aux2,
  output logic              delta_any
);
  localparam int WORD_W = 2 * NIB_W;

  nib_t              raw_lines, sync_lines, loop_lines, pins;
  logic [CTL_W-1:0]  ctl;
  logic [WORD_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    raw_lines        = '0;
    raw_lines[L_DCD] = line_dcd;
    raw_lines[L_RI]  = line_ri;
    raw_lines[L_DSR] = line_dsr;
    raw_lines[L_CTS] = line_cts;
    // crossed loop-test mapping
    loop_lines        = '0;
    loop_lines[L_DCD] = ctl[C_AUX2];
    loop_lines[L_RI]  = ctl[C_AUX1];
    loop_lines[L_DSR] = ctl[C_DTR];
    loop_lines[L_CTS] = ctl[C_RTS];
  end

  mdm_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL(STAT_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_lines),
    .q_o (sync_lines)
  );

  mdm_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (reg_wr_en & ~reg_sel),
    .wdata_i (wr_data),
    .ctl_o   (ctl),
    .pins_o  (pins)
  );

  mdm_stat_reg u_stat (
    .clk          (clk),
    .rst          (rst),
    .ext_i        (sync_lines),
    .loop_i       (ctl[C_LOOP]),
    .loop_lines_i (loop_lines),
    .rd_clr_i     (reg_rd_en & reg_sel),
    .word_o       (stat_word),
    .delta_any_o  (delta_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (reg_rd_en) begin
      rd_q <= reg_sel ? DATA_W'(stat_word) : DATA_W'(ctl);
    end
  end

  assign rd_data  = rd_q;
  assign out_dtr  = pins[C_DTR];
  assign out_rts  = pins[C_RTS];
  assign out_aux1 = pins[C_AUX1];
  assign out_aux2 = pins[C_AUX2];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> $stable(rd_data)); // R11
endmodule

// File: tb/mdm_ctrl_stat_tb.sv
module mdm_ctrl_stat_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic line_cts = 1'b1, line_dsr = 1'b1, line_dcd = 1'b1, line_ri = 1'b0;
  logic out_dtr, out_rts, out_aux1, out_aux2, delta_any;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  mdm_ctrl_stat dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
    .out_dtr(out_dtr), .out_rts(out_rts), .out_aux1(out_aux1), .out_aux2(out_aux2),
    .delta_any(delta_any)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic sel, output logic [7:0] val);
    @(negedge clk);
    reg_sel = sel; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b0; wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, out_aux2, out_aux1, out_rts, out_dtr};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    check("R8 pins", pins(), 8'h08);
    check("R8 delta_any", {7'h0, delta_any}, 8'h00);
    do_read(1'b1, v); check("R8 status", v, 8'hB0);
    do_read(1'b0, v); check("R8 control", v, 8'h08);
  endtask

  task automatic t_cts_delta();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    idle(4);
    check("R9 delta_any set", {7'h0, delta_any}, 8'h01);
    do_read(1'b1, v); check("R2 cts change", v, 8'hA1);
    idle(1);
    check("R9 delta_any cleared", {7'h0, delta_any}, 8'h00);
    do_read(1'b1, v); check("R4 cleared", v, 8'hA0);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    @(negedge clk); line_ri = 1'b1;
    idle(4);
    do_read(1'b1, v); check("R3 ring rise no flag", v, 8'hE0);
    @(negedge clk); line_ri = 1'b0;
    idle(4);
    do_read(1'b1, v); check("R3 ring fall flag", v, 8'hA4);
    @(negedge clk); line_dcd = 1'b0; line_dsr = 1'b0;
    idle(4);
    do_read(1'b1, v); check("R2 dcd dsr flags", v, 8'h0A);
    do_read(1'b1, v); check("R1 upper kept", v, 8'h00);
  endtask

  task automatic t_read_collision();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b1;
    @(posedge clk); @(posedge clk);
    do_read(1'b1, v); check("R4 read on flag edge", v, 8'h00);
    do_read(1'b1, v); check("R4 flag kept", v, 8'h11);
    do_read(1'b1, v); check("R4 flag cleared", v, 8'h10);
  endtask

  task automatic t_control();
    logic [7:0] v;
    do_write(8'hEF);
    check("R5 pins all", pins(), 8'h0F);
    do_read(1'b0, v); check("R5 upper bits dropped", v, 8'h0F);
    do_write(8'h05);
    check("R5 pins dtr aux1", pins(), 8'h05);
    idle(3);
    check("R11 rd_data held", rd_data, 8'h0F);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    @(negedge clk); line_cts = 1'b0;
    idle(4);
    do_write(8'h1A);
    check("R6 pins low", pins(), 8'h00);
    do_read(1'b1, v); check("R7 loop map a", v, 8'h90);
    @(negedge clk); line_dsr = 1'b1;
    idle(4);
    check("R7 loop keeps flag", {7'h0, delta_any}, 8'h01);
    do_write(8'h15);
    check("R6 pins low b", pins(), 8'h00);
    do_read(1'b1, v); check("R7 loop map b", v, 8'h60);
    do_write(8'h00);
    idle(4);
    do_read(1'b1, v); check("R10 no stale flag", v, 8'h21);
    do_read(1'b1, v); check("R10 cleared", v, 8'h20);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(4);
    t_reset();
    t_cts_delta();
    t_ring();
    t_read_collision();
    t_control();
    t_loop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule